// File: doc/BRIEF.md
# Multiplexed Three-Decade BCD Counter

This block counts falling edges on a slow count input using a chain of decimal decades. The default is three decades, which gives a range of 000 to 999. The decades carry synchronously, so a count that rolls several digits, such as 099 to 100, updates all of them on the same clock. A four-bit holding register sits behind each decade. While the hold control is released, the register follows its decade. While the hold control is raised, the register keeps the value it had, so a reading can be frozen while counting goes on.

The held digits leave the block one at a time on a single four-bit bus. A one-hot select output names the digit currently on the bus, so it can drive the common line of a multiplexed display directly. The select moves on every tick of a prescaler that divides the system clock. Everything runs on one system clock. The count input is synchronised with flip-flops, and its falling edges are found by comparing successive samples.

Top module: `bcd3_scan_counter`

## Requirements
- R1: While and after `master_reset` is high, every decade and every holding register is 0, `digit_sel` is 3'b001 (bit 0 names the least significant digit), `digit_bus` is 0 and `overflow` is 0.
- R2: With `count_disable` low, each high-to-low transition of `count_in` adds exactly one to the decimal count. A low-to-high transition adds nothing.
- R3: Each digit stays within 0 to 9. When a digit wraps from 9 to 0, the next digit up advances on the same count event, so 099 becomes 100 in one step.
- R4: A count event at 999 gives 000, and `overflow` is high for exactly one system clock. `overflow` is never high at any other time.
- R5: While `count_disable` is high, falling edges of `count_in` are dropped and the count does not change. They are not deferred to a later time.
- R6: While `latch_enable` is low, each holding register follows its decade. While `latch_enable` is high, the holding registers keep their value whatever the decades do.
- R7: While `master_reset` is high, falling edges of `count_in` are not counted.
- R8: `digit_sel` is always one-hot. It steps bit0 → bit1 → bit2 → bit0 once every SCAN_DIV system clocks and at no other time.
- R9: `digit_bus` carries the held digit named by `digit_sel`. The bus and the select update on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| master_reset | input | 1 | Asynchronous active-high reset of all state; blocks counting while high |
| count_in | input | 1 | Asynchronous count input; its falling edges are counted |
| count_disable | input | 1 | High: count edges are ignored |
| latch_enable | input | 1 | High: holding registers keep their value; low: they follow the decades |
| digit_bus | output | 4 | BCD value of the selected held digit |
| digit_sel | output | NUM_DIGITS | One-hot digit select; bit 0 is the least significant digit |
| overflow | output | 1 | One-clock pulse when the count wraps from all nines to zero |

## Verification
On every clock, the checker confirms the following:
- the select is one-hot and moves only on a prescaler tick, to the next digit;
- each digit is a valid BCD value;
- the bus matches the held digit that the select names;
- the held values do not move while `latch_enable` is high;
- the count does not move while counting is disabled;
- every overflow pulse comes from an all-nines count that wrapped to zero.

Some behaviours can be shown only by the bench's scenarios. These are:
- the exact count of falling edges, and the fact that rising edges add nothing;
- the carry from 099 to 100;
- that the overflow pulses exactly once at the wrap;
- that edges during disable or reset are lost and not deferred;
- the scan period.

// File: rtl/bcdscan_pkg.sv
package bcdscan_pkg;
   localparam int BCD_W     = 4;
   localparam int BCD_LIMIT = 9;

   typedef logic [BCD_W-1:0] bcd_t;

   function automatic bcd_t bcd_step(input bcd_t v);
      return (v >= bcd_t'(BCD_LIMIT)) ? '0 : v + bcd_t'(1);
   endfunction

   function automatic logic bcd_is_top(input bcd_t v);
      return v == bcd_t'(BCD_LIMIT);
   endfunction
endpackage

// File: rtl/bcdscan_edge.sv
module bcdscan_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic fall_o
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("bcdscan_edge: SYNC_STAGES must be at least 2");
      end
      else begin : g_sync
         always_ff @(posedge clk or posedge rst) begin
            if (rst) begin
               sync_q <= '0;
               prev_q <= 1'b0;
            end
            else begin
               sync_q <= {sync_q[SYNC_STAGES-2:0], din};
               prev_q <= sync_q[SYNC_STAGES-1];
            end
         end
      end
   endgenerate

   assign fall_o = prev_q & ~sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/bcdscan_decade.sv
module bcdscan_decade
   import bcdscan_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic step_i,
   output bcd_t value_o,
   output logic at_top_o
);
   bcd_t value_q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst)         value_q <= '0;
      else if (step_i) value_q <= bcd_step(value_q);
   end

   assign value_o  = value_q;
   assign at_top_o = bcd_is_top(value_q);
endmodule

// File: rtl/bcdscan_hold.sv
module bcdscan_hold
   import bcdscan_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic freeze_i,
   input  bcd_t d_i,
   output bcd_t q_o
);
   bcd_t q_r;

   always_ff @(posedge clk or posedge rst) begin
      if (rst)            q_r <= '0;
      else if (!freeze_i) q_r <= d_i;
   end

   assign q_o = q_r;
endmodule

// File: rtl/bcdscan_scan.sv
module bcdscan_scan
   import bcdscan_pkg::*;
#(
   parameter int NUM_DIGITS = 3,
   parameter int SCAN_DIV   = 4
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic [NUM_DIGITS*BCD_W-1:0] digits_i,
   output logic [NUM_DIGITS-1:0]       sel_o,
   output bcd_t                        bus_o,
   output logic                        tick_o
);
   localparam int PW       = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;
   localparam bit POW2_DIV = (SCAN_DIV & (SCAN_DIV - 1)) == 0;

   logic [PW-1:0]         pre_q;
   logic [NUM_DIGITS-1:0] sel_q, sel_n;
   bcd_t                  bus_q, bus_n;

   assign tick_o = pre_q == PW'(SCAN_DIV - 1);

   generate
      if (SCAN_DIV < 2) begin : g_bad_div
         $error("bcdscan_scan: SCAN_DIV must be at least 2");
      end
      else if (POW2_DIV) begin : g_pre_wrap
         always_ff @(posedge clk or posedge rst) begin
            if (rst) pre_q <= '0;
            else     pre_q <= pre_q + PW'(1);
         end
      end
      else begin : g_pre_cmp
         always_ff @(posedge clk or posedge rst) begin
            if (rst)         pre_q <= '0;
            else if (tick_o) pre_q <= '0;
            else             pre_q <= pre_q + PW'(1);
         end
      end
   endgenerate

   always_comb begin
      sel_n = tick_o ? {sel_q[NUM_DIGITS-2:0], sel_q[NUM_DIGITS-1]} : sel_q;
      bus_n = '0;
      for (int i = 0; i < NUM_DIGITS; i++) begin
         if (sel_n[i]) bus_n = bus_n | digits_i[i*BCD_W +: BCD_W];
      end
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         sel_q <= NUM_DIGITS'(1);
         bus_q <= '0;
      end
      else begin
         sel_q <= sel_n;
         bus_q <= bus_n;
      end
   end

   assign sel_o = sel_q;
   assign bus_o = bus_q;
endmodule

// File: rtl/bcd3_scan_counter.sv
module bcd3_scan_counter
   import bcdscan_pkg::*;
#(
   parameter int NUM_DIGITS  = 3,
   parameter int SCAN_DIV    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  master_reset,
   input  logic                  count_in,
   input  logic                  count_disable,
   input  logic                  latch_enable,
   output logic [BCD_W-1:0]      digit_bus,
   output logic [NUM_DIGITS-1:0] digit_sel,
   output logic                  overflow
);
   localparam int FLAT_W = NUM_DIGITS * BCD_W;

   logic              fall;
   logic [NUM_DIGITS:0] carry;
   logic [NUM_DIGITS-1:0] at_top;
   logic [FLAT_W-1:0] count_flat;
   logic [FLAT_W-1:0] latch_flat;
   logic              scan_tick;
   logic              ovf_q;

   generate
      if (NUM_DIGITS < 2) begin : g_bad_digits
         $error("bcd3_scan_counter: NUM_DIGITS must be at least 2");
      end
   endgenerate

   bcdscan_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .rst    (master_reset),
      .din    (count_in),
      .fall_o (fall)
   );

   assign carry[0] = fall & ~count_disable;

   generate
      for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
         bcd_t dec_v, hold_v;

         bcdscan_decade u_decade (
            .clk      (clk),
            .rst      (master_reset),
            .step_i   (carry[i]),
            .value_o  (dec_v),
            .at_top_o (at_top[i])
         );

         assign carry[i+1] = carry[i] & at_top[i];
         assign count_flat[i*BCD_W +: BCD_W] = dec_v;

         bcdscan_hold u_hold (
            .clk      (clk),
            .rst      (master_reset),
            .freeze_i (latch_enable),
            .d_i      (dec_v),
            .q_o      (hold_v)
         );

         assign latch_flat[i*BCD_W +: BCD_W] = hold_v;
      end
   endgenerate

   always_ff @(posedge clk or posedge master_reset) begin
      if (master_reset) ovf_q <= 1'b0;
      else              ovf_q <= carry[NUM_DIGITS];
   end

   bcdscan_scan #(.NUM_DIGITS(NUM_DIGITS), .SCAN_DIV(SCAN_DIV)) u_scan (
      .clk      (clk),
      .rst      (master_reset),
      .digits_i (latch_flat),
      .sel_o    (digit_sel),
      .bus_o    (digit_bus),
      .tick_o   (scan_tick)
   );

   assign overflow = ovf_q;
endmodule

// File: rtl/bcd3_scan_counter_chk.sv
module bcd3_scan_counter_chk #(
   parameter int NUM_DIGITS = 3
) (
   input logic                    clk,
   input logic                    master_reset,
   input logic                    count_disable,
   input logic                    latch_enable,
   input logic [NUM_DIGITS*4-1:0] count_flat,
   input logic [NUM_DIGITS*4-1:0] latch_flat,
   input logic [NUM_DIGITS-1:0]   digit_sel,
   input logic [3:0]              digit_bus,
   input logic                    scan_tick,
   input logic                    overflow
);
   localparam int FW = NUM_DIGITS * 4;

   function automatic logic [FW-1:0] all_nines();
      logic [FW-1:0] v;
      for (int i = 0; i < NUM_DIGITS; i++) v[i*4 +: 4] = 4'd9;
      return v;
   endfunction

   function automatic logic digits_ok(input logic [FW-1:0] v);
      logic ok = 1'b1;
      for (int i = 0; i < NUM_DIGITS; i++) if (v[i*4 +: 4] > 4'd9) ok = 1'b0;
      return ok;
   endfunction

   function automatic logic [3:0] pick(input logic [FW-1:0] v,
                                       input logic [NUM_DIGITS-1:0] s);
      logic [3:0] r = '0;
      for (int i = 0; i < NUM_DIGITS; i++) if (s[i]) r = r | v[i*4 +: 4];
      return r;
   endfunction

   assert_sel_onehot_R8: assert property (@(posedge clk) disable iff (master_reset)
      $countones(digit_sel) == 1);

   assert_sel_moves_on_tick_R8: assert property (@(posedge clk) disable iff (master_reset)
      !$stable(digit_sel) |-> ($past(scan_tick) &&
         digit_sel == {$past(digit_sel[NUM_DIGITS-2:0]), $past(digit_sel[NUM_DIGITS-1])}));

   assert_bus_matches_sel_R9: assert property (@(posedge clk) disable iff (master_reset)
      digit_bus == pick($past(latch_flat), digit_sel));

   assert_digit_range_R3: assert property (@(posedge clk) disable iff (master_reset)
      digits_ok(count_flat) && digits_ok(latch_flat));

   assert_wrap_pulse_R4: assert property (@(posedge clk) disable iff (master_reset)
      overflow |-> (count_flat == '0 && $past(count_flat) == all_nines()));

   assert_disable_freezes_R5: assert property (@(posedge clk) disable iff (master_reset)
      count_disable |=> $stable(count_flat));

   assert_hold_frozen_R6: assert property (@(posedge clk) disable iff (master_reset)
      latch_enable |=> $stable(latch_flat));
endmodule

bind bcd3_scan_counter bcd3_scan_counter_chk #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
   .clk           (clk),
   .master_reset  (master_reset),
   .count_disable (count_disable),
   .latch_enable  (latch_enable),
   .count_flat    (count_flat),
   .latch_flat    (latch_flat),
   .digit_sel     (digit_sel),
   .digit_bus     (digit_bus),
   .scan_tick     (scan_tick),
   .overflow      (overflow)
);

// File: tb/bcd3_scan_counter_bench.sv
`timescale 1ns/1ps
module bcd3_scan_counter_bench;
   localparam int SCAN_DIV = 4;

   logic       clk = 1'b0;
   logic       master_reset = 1'b1;
   logic       count_in = 1'b0;
   logic       count_disable = 1'b0;
   logic       latch_enable = 1'b0;
   logic [3:0] digit_bus;
   logic [2:0] digit_sel;
   logic       overflow;

   int total = 0;
   int bad = 0;
   int ovf_pulses = 0;
   int ovf_long = 0;
   logic ovf_prev = 1'b0;
   int model = 0;
   int held = 0;

   always #4 clk = ~clk;

   bcd3_scan_counter #(.NUM_DIGITS(3), .SCAN_DIV(SCAN_DIV), .SYNC_STAGES(2)) u_bcd3_scan_counter (
      .clk (clk), .master_reset (master_reset), .count_in (count_in),
      .count_disable (count_disable), .latch_enable (latch_enable),
      .digit_bus (digit_bus), .digit_sel (digit_sel), .overflow (overflow)
   );

   always @(negedge clk) begin
      if (overflow) ovf_pulses++;
      if (overflow && ovf_prev) ovf_long++;
      ovf_prev = overflow;
   end

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic pulse();
      @(negedge clk) count_in = 1'b1;
      repeat (3) @(negedge clk);
      count_in = 1'b0;
      repeat (3) @(negedge clk);
      if (!count_disable && !master_reset) model = (model + 1) % 1000;
   endtask

   task automatic read_value(output int v);
      int d [3];
      repeat (4) @(negedge clk);
      for (int k = 0; k < 3; k++) begin
         do @(negedge clk); while (digit_sel != 3'(1 << k));
         d[k] = int'(digit_bus);
      end
      v = d[2] * 100 + d[1] * 10 + d[0];
   endtask

   function automatic int expect_view();
      return latch_enable ? held : model;
   endfunction

   initial begin
      #(200000 * 8);
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int v;
      int seed;
      int n;
      int t0;
      logic [2:0] s0;
      seed = $urandom(32'd2024);

      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 sel in reset", int'(digit_sel), 1);
      chk("R1 bus in reset", int'(digit_bus), 0);
      master_reset = 1'b0;
      @(negedge clk);
      chk("R1 overflow after reset", int'(overflow), 0);
      read_value(v);
      chk("R1 value after reset", v, 0);

      // R2: one falling edge; rising edge alone adds nothing
      pulse();
      read_value(v);
      chk("R2 single edge", v, 1);
      @(negedge clk) count_in = 1'b1;
      read_value(v);
      chk("R2 rising edge ignored", v, 1);
      @(negedge clk) count_in = 1'b0;
      repeat (3) @(negedge clk);
      model = 2;
      read_value(v);
      chk("R2 falling edge after rise", v, 2);

      // R3: carry 099 -> 100
      while (model != 99) pulse();
      read_value(v);
      chk("R3 at 099", v, 99);
      pulse();
      read_value(v);
      chk("R3 carry to 100", v, 100);

      // R4: wrap 999 -> 000 with one overflow pulse
      while (model != 999) pulse();
      read_value(v);
      chk("R4 at 999", v, 999);
      chk("R4 no overflow before wrap", ovf_pulses, 0);
      pulse();
      read_value(v);
      chk("R4 wrap to 000", v, 0);
      chk("R4 overflow pulse count", ovf_pulses, 1);
      chk("R4 overflow one clock wide", ovf_long, 0);

      // R5: disable drops edges
      count_disable = 1'b1;
      repeat (5) pulse();
      count_disable = 1'b0;
      read_value(v);
      chk("R5 edges dropped while disabled", v, 0);
      pulse();
      read_value(v);
      chk("R5 counts again after disable", v, 1);

      // R6: hold freezes bus view while count continues
      latch_enable = 1'b1;
      held = model;
      repeat (7) pulse();
      read_value(v);
      chk("R6 held value", v, held);
      latch_enable = 1'b0;
      read_value(v);
      chk("R6 follows after release", v, model);

      // R7: reset blocks counting
      master_reset = 1'b1;
      model = 0;
      repeat (3) pulse();
      chk("R7 sel held in reset", int'(digit_sel), 1);
      chk("R7 bus zero in reset", int'(digit_bus), 0);
      master_reset = 1'b0;
      read_value(v);
      chk("R7 no counts during reset", v, 0);

      // R8: scan period and order
      @(negedge clk);
      s0 = digit_sel;
      do @(negedge clk); while (digit_sel == s0);
      s0 = digit_sel;
      t0 = 0;
      do begin @(negedge clk); t0++; end while (digit_sel == s0);
      chk("R8 scan period", t0, SCAN_DIV);
      chk("R8 rotation order", int'(digit_sel), int'({s0[1:0], s0[2]}));

      // R9 plus random mix of R2/R5/R6
      for (int it = 0; it < 60; it++) begin
         if ($urandom_range(0, 3) == 0) begin
            if (!latch_enable) held = model;
            latch_enable = ~latch_enable;
            repeat (3) @(negedge clk);
         end
         count_disable = ($urandom_range(0, 3) == 0);
         n = $urandom_range(0, 12);
         for (int p = 0; p < n; p++) pulse();
         count_disable = 1'b0;
         read_value(v);
         chk("R9 random scan readout", v, expect_view());
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule